// File: doc/BRIEF.md
# Five-Step Multi-Cycle Byte Processor Core

This block is a small processor core with separate instruction and data memory ports. It holds a program counter, an instruction register and a bank of sixteen 8-bit general registers. Every instruction is one 16-bit word, and the core runs it through five clock cycles in a fixed order: fetch, decode, operand read, execute and write-back. A step that an instruction has no use for still takes its cycle. Both memories are synchronous, with read data returned on the cycle after the address. They sit outside the core, and the core can use both of them in the same cycle.

The instruction word has four fields. Bits [15:12] hold the opcode and bits [11:8] hold the destination register index `d`. Bits [7:0] hold a byte field `k`, whose bits [7:4] also serve as the source register index `s`. Seven opcodes are defined. Opcode 0 loads from a direct data address and opcode 1 stores to one. Opcode 2 stores through a register pointer and opcode 3 loads an immediate. Opcodes 4 and 5 add and subtract. Opcode 6 is a relative branch taken when the register is zero. Any other opcode halts the core until reset.

Top module: `tinyCpu`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0, clears all sixteen registers to 0 and returns the sequencer to its fetch step. While reset is held, `imemAddr` is 0, `halted` is 0 and `dmemWe` is 0.
- R2: Each instruction takes exactly five clock cycles. `imemAddr` shows the program counter and changes only at the end of the fifth cycle of an instruction.
- R3: Opcode 0 sets register d to the data memory byte at address k. Opcode 1 writes register d to data memory address k.
- R4: Opcode 2 writes register s to the data memory address held in register d. Opcode 3 sets register d to k.
- R5: Opcode 4 sets register d to d+s and opcode 5 sets it to d−s, both modulo 256.
- R6: For opcode 6, when register d is zero the next program counter is the branch's own address plus k, read as a signed two's-complement byte and wrapped to 10 bits.
- R7: When opcode 6 finds register d nonzero, and after every opcode 0 to 5, the program counter advances by one.
- R8: An opcode from 7 to 15 sets `halted` one cycle after its decode step. The core then makes no further register or memory writes and holds the program counter at the illegal word until reset.
- R9: `dmemWe` is high only in the fifth cycle of opcode 1 or 2. In that cycle `dmemAddr` is k for opcode 1 and register d for opcode 2. `dmemWrData` is register d for opcode 1 and register s for opcode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imemAddr | output | 10 | Instruction memory word address (program counter) |
| imemData | input | 16 | Instruction word, valid one cycle after address |
| dmemAddr | output | 8 | Data memory byte address |
| dmemWrData | output | 8 | Data memory write byte |
| dmemWe | output | 1 | Data memory write enable |
| dmemRdData | input | 8 | Data memory read byte, valid one cycle after address |
| halted | output | 1 | High once an illegal opcode has been decoded |

## Verification
The registers cannot be seen from the ports. A wrong register write therefore stays hidden until some later store or branch exposes it. Every program ends by storing the values under test, so register state reaches the data port, where the bench model compares address and data on each store cycle and compares the whole data memory after the halt.

Several cases need a particular setup. To check the reset clear, a program first leaves nonzero registers behind, and then a second program stores a register it has never written. A backward branch with a negative offset comes from a summing loop from 10 down to 1. To show that nothing runs after a halt, a store is placed right after the illegal word.

// File: rtl/cpuPkg.sv
`timescale 1ns/1ps
package cpuPkg;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_OPER   = 3'd2,
    PH_EXEC   = 3'd3,
    PH_STORE  = 3'd4,
    PH_HALT   = 3'd5
  } phase_t;

  localparam logic [3:0] OP_LDD  = 4'd0;  // d = mem[k]
  localparam logic [3:0] OP_STD  = 4'd1;  // mem[k] = d
  localparam logic [3:0] OP_STI  = 4'd2;  // mem[d] = s
  localparam logic [3:0] OP_LDI  = 4'd3;  // d = k
  localparam logic [3:0] OP_ADD  = 4'd4;
  localparam logic [3:0] OP_SUB  = 4'd5;
  localparam logic [3:0] OP_JZ   = 4'd6;
  localparam logic [3:0] OP_LAST = OP_JZ;

  typedef struct packed {
    logic irLoad;
    logic opsLoad;
    logic resLoad;
    logic regWrite;
    logic memWrite;
    logic pcLoad;
  } strobes_t;

endpackage

// File: rtl/cpuRegFile.sv
`timescale 1ns/1ps
module cpuRegFile #(
  parameter int DATA_W  = 8,
  parameter int REG_CNT = 16,
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);

  logic [DATA_W-1:0] regs [REG_CNT];

  for (genvar g = 0; g < REG_CNT; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (wrEn && wrIdx == IDX_W'(g)) begin
        regs[g] <= wrData;
      end
    end
  end

  assign rdDataA = regs[rdIdxA];
  assign rdDataB = regs[rdIdxB];

endmodule

// File: rtl/cpuCtrl.sv
`timescale 1ns/1ps
module cpuCtrl
  import cpuPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] fetchOp,
  input  logic [3:0] irOp,
  output strobes_t   strobes,
  output phase_t     phase,
  output logic       halted
);

  phase_t phaseNext;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH;
    else     phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    strobes   = '0;
    case (phase)
      PH_FETCH:  phaseNext = PH_DECODE;
      PH_DECODE: begin
        if (fetchOp > OP_LAST) begin
          phaseNext = PH_HALT;
        end else begin
          strobes.irLoad = 1'b1;
          phaseNext      = PH_OPER;
        end
      end
      PH_OPER: begin
        strobes.opsLoad = 1'b1;
        phaseNext       = PH_EXEC;
      end
      PH_EXEC: begin
        strobes.resLoad = 1'b1;
        phaseNext       = PH_STORE;
      end
      PH_STORE: begin
        case (irOp)
          OP_LDD, OP_LDI, OP_ADD, OP_SUB: strobes.regWrite = 1'b1;
          OP_STD, OP_STI:                 strobes.memWrite = 1'b1;
          default: ;
        endcase
        strobes.pcLoad = 1'b1;
        phaseNext      = PH_FETCH;
      end
      PH_HALT:  phaseNext = PH_HALT;
      default:  phaseNext = PH_HALT;
    endcase
  end

  assign halted = (phase == PH_HALT);

endmodule

// File: rtl/cpuDatapath.sv
`timescale 1ns/1ps
module cpuDatapath
  import cpuPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PC_W    = 10,
  parameter int REG_CNT = 16,
  localparam int INSTR_W = 2 * DATA_W,
  localparam int IDX_W   = $clog2(REG_CNT)
) (
  input  logic               clk,
  input  logic               rst,
  input  strobes_t           strobes,
  input  logic [INSTR_W-1:0] imemData,
  input  logic [DATA_W-1:0]  dmemRdData,
  output logic [PC_W-1:0]    pc,
  output logic [3:0]         irOp,
  output logic [DATA_W-1:0]  dmemAddr,
  output logic [DATA_W-1:0]  dmemWrData
);

  logic [INSTR_W-1:0] ir;
  logic [DATA_W-1:0]  opA, opB, res, aluOut;
  logic [DATA_W-1:0]  rdA, rdB, field;
  logic [IDX_W-1:0]   idxD, idxS;
  logic [PC_W-1:0]    pcNext, branchOff;

  assign irOp  = ir[INSTR_W-1 -: 4];
  assign idxD  = ir[INSTR_W-5 -: IDX_W];
  assign field = ir[DATA_W-1:0];
  assign idxS  = field[DATA_W-1 -: IDX_W];

  cpuRegFile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) uRegs (
    .clk     (clk),
    .rst     (rst),
    .rdIdxA  (idxD),
    .rdIdxB  (idxS),
    .wrEn    (strobes.regWrite),
    .wrIdx   (idxD),
    .wrData  (res),
    .rdDataA (rdA),
    .rdDataB (rdB)
  );

  always_comb begin
    case (irOp)
      OP_LDD:  aluOut = dmemRdData;
      OP_LDI:  aluOut = field;
      OP_ADD:  aluOut = opA + opB;
      OP_SUB:  aluOut = opA - opB;
      default: aluOut = opA;
    endcase
  end

  assign branchOff = {{(PC_W-DATA_W){field[DATA_W-1]}}, field};

  always_comb begin
    if (irOp == OP_JZ && opA == '0) pcNext = pc + branchOff;
    else                            pcNext = pc + PC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ir  <= '0;
      opA <= '0;
      opB <= '0;
      res <= '0;
    end else begin
      if (strobes.irLoad)  ir  <= imemData;
      if (strobes.opsLoad) begin
        opA <= rdA;
        opB <= rdB;
      end
      if (strobes.resLoad) res <= aluOut;
      if (strobes.pcLoad)  pc  <= pcNext;
    end
  end

  assign dmemAddr   = (irOp == OP_STI) ? opA : field;
  assign dmemWrData = (irOp == OP_STI) ? opB : opA;

endmodule

// File: rtl/tinyCpu.sv
`timescale 1ns/1ps
module tinyCpu
  import cpuPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PC_W    = 10,
  parameter int REG_CNT = 16,
  localparam int INSTR_W = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    imemAddr,
  input  logic [INSTR_W-1:0] imemData,
  output logic [DATA_W-1:0]  dmemAddr,
  output logic [DATA_W-1:0]  dmemWrData,
  output logic               dmemWe,
  input  logic [DATA_W-1:0]  dmemRdData,
  output logic               halted
);

  strobes_t ctrlStrobes;
  phase_t   ctrlPhase;
  logic [3:0] irOp;

  cpuCtrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .fetchOp (imemData[INSTR_W-1 -: 4]),
    .irOp    (irOp),
    .strobes (ctrlStrobes),
    .phase   (ctrlPhase),
    .halted  (halted)
  );

  cpuDatapath #(.DATA_W(DATA_W), .PC_W(PC_W), .REG_CNT(REG_CNT)) uPath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (ctrlStrobes),
    .imemData   (imemData),
    .dmemRdData (dmemRdData),
    .pc         (imemAddr),
    .irOp       (irOp),
    .dmemAddr   (dmemAddr),
    .dmemWrData (dmemWrData)
  );

  assign dmemWe = ctrlStrobes.memWrite;

endmodule

// File: rtl/cpuChecker.sv
`timescale 1ns/1ps
module cpuChecker
  import cpuPkg::*;
#(
  parameter int PC_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] imemAddr,
  input logic            dmemWe,
  input logic            halted,
  input phase_t          phase
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (imemAddr == '0 && !halted && phase == PH_FETCH));

  a_r2_pc_held_mid_instr: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_STORE) |=> $stable(imemAddr));

  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  a_r8_pc_frozen: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(imemAddr));

  a_r9_no_write_halted: assert property (@(posedge clk) disable iff (rst)
    halted |-> !dmemWe);

  a_r9_write_in_store_step: assert property (@(posedge clk) disable iff (rst)
    dmemWe |-> (phase == PH_STORE));

endmodule

bind tinyCpu cpuChecker #(.PC_W(PC_W)) chk (
  .clk      (clk),
  .rst      (rst),
  .imemAddr (imemAddr),
  .dmemWe   (dmemWe),
  .halted   (halted),
  .phase    (ctrlPhase)
);

// File: tb/tinyCpu_test.sv
`timescale 1ns/1ps
module tinyCpu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  imemAddr;
  logic [15:0] imemData;
  logic [7:0]  dmemAddr, dmemWrData, dmemRdData;
  logic        dmemWe, halted;

  always #10 clk = ~clk;  // 50 MHz

  tinyCpu uut (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWrData(dmemWrData), .dmemWe(dmemWe),
    .dmemRdData(dmemRdData), .halted(halted)
  );

  logic [15:0] imem     [1024];
  logic [7:0]  dmemInit [256];
  logic [7:0]  dmem     [256];

  always @(posedge clk) begin
    imemData   <= imem[imemAddr];
    dmemRdData <= dmem[dmemAddr];
    if (rst) begin
      for (int i = 0; i < 256; i++) dmem[i] <= dmemInit[i];
    end else if (dmemWe) begin
      dmem[dmemAddr] <= dmemWrData;
    end
  end

  int total = 0;
  int bad   = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] mreg [16];
  logic [7:0] mmem [256];
  int mpc, mphase;
  bit mhalt;

  task automatic modelReset();
    for (int i = 0; i < 16; i++) mreg[i] = 8'h00;
    for (int i = 0; i < 256; i++) mmem[i] = dmemInit[i];
    mpc = 0; mphase = 0; mhalt = 0;
  endtask

  task automatic modelStep();
    logic [15:0] w;
    int op, d, s, k;
    w  = imem[mpc];
    op = int'(w[15:12]); d = int'(w[11:8]); k = int'(w[7:0]); s = int'(w[7:4]);
    chk("R8 halted", int'(halted), int'(mhalt));
    chk("R2 pc", int'(imemAddr), mpc);
    if (!mhalt && mphase == 4 && (op == 1 || op == 2)) begin
      chk("R9 we", int'(dmemWe), 1);
      chk("R9 addr", int'(dmemAddr), (op == 1) ? k : int'(mreg[d]));
      chk("R9 data", int'(dmemWrData), (op == 1) ? int'(mreg[d]) : int'(mreg[s]));
    end else begin
      chk("R9 no we", int'(dmemWe), 0);
    end
    if (mhalt) return;
    if (mphase == 1 && op > 6) begin
      mhalt = 1;
    end else if (mphase == 4) begin
      case (op)
        0: mreg[d] = mmem[k];
        1: mmem[k] = mreg[d];
        2: mmem[mreg[d]] = mreg[s];
        3: mreg[d] = 8'(k);
        4: mreg[d] = mreg[d] + mreg[s];
        5: mreg[d] = mreg[d] - mreg[s];
        default: ;
      endcase
      if (op == 6 && mreg[d] == 8'h00) mpc = (mpc + int'($signed(w[7:0]))) & 1023;
      else                             mpc = (mpc + 1) & 1023;
      mphase = 0;
    end else begin
      mphase++;
    end
  endtask

  task automatic runProg(input int maxCycles);
    int haltCycles = 0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    // R1: outputs while reset is held
    chk("R1 reset pc", int'(imemAddr), 0);
    chk("R1 reset halted", int'(halted), 0);
    chk("R1 reset we", int'(dmemWe), 0);
    rst = 1'b0;
    modelReset();
    for (int c = 0; c < maxCycles; c++) begin
      modelStep();
      if (mhalt) haltCycles++;
      if (haltCycles > 12) break;
      @(negedge clk);
    end
    if (!mhalt) chk("watchdog program halt", 0, 1);
    begin
      int mism = 0;
      for (int a = 0; a < 256; a++) if (dmem[a] !== mmem[a]) mism++;
      chk("R3 R4 R5 memory image", mism, 0);
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) imem[i] = 16'hF000;
    for (int i = 0; i < 256; i++) dmemInit[i] = 8'(i * 7 + 3);

    // Program 1: sum 10..1, backward branch with negative offset (R6, R7)
    imem[0] = 16'h3000; imem[1] = 16'h310A; imem[2] = 16'h3201; imem[3] = 16'h3300;
    imem[4] = 16'h6104; imem[5] = 16'h4010; imem[6] = 16'h5120; imem[7] = 16'h63FD;
    imem[8] = 16'h1080; imem[9] = 16'h7000;
    runProg(2000);
    chk("R6 sum loop result", int'(dmem[8'h80]), 55);
    chk("R8 pc frozen at illegal", int'(imemAddr), 9);

    // Program 2: reset clears regs, load/add wrap/sub wrap/indirect store
    for (int i = 0; i < 1024; i++) imem[i] = 16'hF000;
    dmemInit[8'h20] = 8'hC8; dmemInit[8'h32] = 8'hAA;
    imem[0]  = 16'h1010;  // mem[10] = R0 (must be 0 after reset)
    imem[1]  = 16'h0420;  // R4 = mem[20]
    imem[2]  = 16'h3564;  // R5 = 100
    imem[3]  = 16'h4450;  // R4 += R5 -> 0x2C
    imem[4]  = 16'h1421;  // mem[21] = R4
    imem[5]  = 16'h3603;  // R6 = 3
    imem[6]  = 16'h5650;  // R6 -= R5 -> 0x9F
    imem[7]  = 16'h3730;  // R7 = 0x30
    imem[8]  = 16'h2760;  // mem[R7] = R6
    imem[9]  = 16'h6605;  // not taken
    imem[10] = 16'h1631;  // mem[31] = R6
    imem[11] = 16'hF123;  // illegal
    imem[12] = 16'h1732;  // must never run
    runProg(2000);
    chk("R1 register cleared by reset", int'(dmem[8'h10]), 0);
    chk("R3 R5 load then add wrap", int'(dmem[8'h21]), 8'h2C);
    chk("R4 R5 indirect store of sub wrap", int'(dmem[8'h30]), 8'h9F);
    chk("R7 fall through after not taken", int'(dmem[8'h31]), 8'h9F);
    chk("R8 no store after illegal", int'(dmem[8'h32]), 8'hAA);
    chk("R8 pc frozen", int'(imemAddr), 11);

    // Program 3: forward taken jump skips a store; jump wraps below 0
    for (int i = 0; i < 1024; i++) imem[i] = 16'hF000;
    imem[0] = 16'h3155;  // R1 = 0x55
    imem[1] = 16'h6203;  // R2==0 -> pc 4
    imem[2] = 16'h1140;  // skipped
    imem[4] = 16'h1141;  // mem[41] = R1
    imem[5] = 16'h60F0;  // R0==0 -> pc 5-16 wraps to 1013
    imem[1013] = 16'h3A09;
    imem[1014] = 16'h1A42;
    imem[1015] = 16'h8000;
    dmemInit[8'h40] = 8'h11;
    runProg(2000);
    chk("R6 taken jump skipped store", int'(dmem[8'h40]), 8'h11);
    chk("R6 store after forward jump", int'(dmem[8'h41]), 8'h55);
    chk("R6 wrap target executed", int'(dmem[8'h42]), 9);
    chk("R8 halt address after wrap", int'(imemAddr), 1015);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule